// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block passes a data word between two ports, A and B, in either direction. Each direction has its own storage register that can follow its source port or freeze a captured word. It also has its own active-low chip select, capture control and drive control, so the two paths are set up independently of each other. A word captured from one port can be placed on the opposite port at any later time.

Real tri-state pins cannot be built inside the fabric, so each port appears as three signals: an input bus, an output bus and an active-high drive-enable flag. A wrapper at the chip top combines them into a bidirectional pin. All state and all outputs are registered on one clock, with a synchronous active-high reset.

Top module: `bus_xcvr_latched`

## Requirements
- R1: While `rst` is high at a clock edge, both storage registers clear to zero. After that edge `a_out` and `b_out` read 0, and `a_drv` and `b_drv` read 0.
- R2: When `ab_sel_n` and `ab_cap_n` are both 0 at a clock edge, the A-to-B register loads `a_in`, and `b_out` shows that word after the edge (transparent mode).
- R3: When `ab_cap_n` is 1 at an edge, the A-to-B register keeps its word. The word held is the one loaded at the last edge that saw `ab_cap_n` at 0, and changes on `a_in` do not reach `b_out`.
- R4: When `ab_sel_n` is 1 at an edge, the A-to-B register keeps its word whatever `ab_cap_n` is. The same holds for the B-to-A register when `ba_sel_n` is 1.
- R5: After an edge, `b_drv` is 1 exactly when `ab_sel_n` and `ab_drv_n` were both 0 at that edge. Otherwise port B is released.
- R6: The B-to-A path behaves as R2 to R5 describe, using `ba_sel_n`, `ba_cap_n` and `ba_drv_n`, with `b_in` as its source and `a_out` and `a_drv` as its output.
- R7: The controls and the data of one direction have no effect on the register or the drive flag of the other direction.
- R8: A port's drive flag is 0 in every cycle in which the drive controls of that port are deasserted. A bench that drives the port from outside only when its own model expects the flag to be 0 therefore never meets the block driving the same port (no contention).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | W | Value seen on port A |
| b_in | input | W | Value seen on port B |
| ab_sel_n | input | 1 | A-to-B chip select, active low |
| ab_cap_n | input | 1 | A-to-B capture, low means follow, high means hold |
| ab_drv_n | input | 1 | A-to-B output drive control, active low |
| ba_sel_n | input | 1 | B-to-A chip select, active low |
| ba_cap_n | input | 1 | B-to-A capture, low means follow, high means hold |
| ba_drv_n | input | 1 | B-to-A output drive control, active low |
| a_out | output | W | Value to drive onto port A (B-to-A register) |
| a_drv | output | 1 | Drive enable for port A, active high |
| b_out | output | W | Value to drive onto port B (A-to-B register) |
| b_drv | output | 1 | Drive enable for port B, active high |

## Verification
Loading a register and enabling its output can fall on the same edge. So can both directions loading while each drives its own far port. The first case is provoked by lowering a direction's select, capture and drive controls together on a new word. It is judged by requiring that the word and the drive flag show up together after that single edge, with no stale word visible while the flag is already set. The second case runs both paths transparent at once, with different words on A and B, and checks that each far port carries only its own source's word.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned NUM_DIRS = 2;
  localparam int unsigned DIR_AB = 0;
  localparam int unsigned DIR_BA = 1;

  // active-low control triple for one direction
  typedef struct packed {
    logic sel_n;
    logic cap_n;
    logic drv_n;
  } dir_ctl_t;

  typedef struct packed {
    logic load;
    logic drive;
  } dir_act_t;
endpackage

// File: rtl/xcvr_ctl_decode.sv
module xcvr_ctl_decode
  import xcvr_pkg::*;
(
  input  dir_ctl_t ctl,
  output dir_act_t act
);
  always_comb begin
    act.load  = ~ctl.sel_n & ~ctl.cap_n;
    act.drive = ~ctl.sel_n & ~ctl.drv_n;
  end
endmodule

// File: rtl/xcvr_latch_path.sv
module xcvr_latch_path
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  dir_ctl_t     ctl,
  input  logic [W-1:0] src,
  output logic [W-1:0] held,
  output logic         drv
);
  dir_act_t act;

  xcvr_ctl_decode dec_i (
    .ctl (ctl),
    .act (act)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '0;
      drv  <= 1'b0;
    end else begin
      if (act.load) held <= src;
      drv <= act.drive;
    end
  end
endmodule

// File: rtl/bus_xcvr_latched.sv
module bus_xcvr_latched
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ab_sel_n,
  input  logic         ab_cap_n,
  input  logic         ab_drv_n,
  input  logic         ba_sel_n,
  input  logic         ba_cap_n,
  input  logic         ba_drv_n,
  output logic [W-1:0] a_out,
  output logic         a_drv,
  output logic [W-1:0] b_out,
  output logic         b_drv
);
  dir_ctl_t     ctl_arr  [NUM_DIRS];
  logic [W-1:0] src_arr  [NUM_DIRS];
  logic [W-1:0] held_arr [NUM_DIRS];
  logic         drv_arr  [NUM_DIRS];

  assign ctl_arr[DIR_AB] = '{sel_n: ab_sel_n, cap_n: ab_cap_n, drv_n: ab_drv_n};
  assign ctl_arr[DIR_BA] = '{sel_n: ba_sel_n, cap_n: ba_cap_n, drv_n: ba_drv_n};
  assign src_arr[DIR_AB] = a_in;
  assign src_arr[DIR_BA] = b_in;

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
    xcvr_latch_path #(.W(W)) path_i (
      .clk  (clk),
      .rst  (rst),
      .ctl  (ctl_arr[d]),
      .src  (src_arr[d]),
      .held (held_arr[d]),
      .drv  (drv_arr[d])
    );
  end

  assign b_out = held_arr[DIR_AB];
  assign b_drv = drv_arr[DIR_AB];
  assign a_out = held_arr[DIR_BA];
  assign a_drv = drv_arr[DIR_BA];
endmodule

// File: rtl/bus_xcvr_latched_chk.sv
module bus_xcvr_latched_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         ab_sel_n,
  input logic         ab_cap_n,
  input logic         ab_drv_n,
  input logic         ba_sel_n,
  input logic         ba_cap_n,
  input logic         ba_drv_n,
  input logic [W-1:0] a_out,
  input logic         a_drv,
  input logic [W-1:0] b_out,
  input logic         b_drv
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (a_out == '0 && b_out == '0 && !a_drv && !b_drv));
  // R2
  ab_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!ab_sel_n && !ab_cap_n) |=> (b_out == $past(a_in)));
  // R3
  ab_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ab_cap_n |=> $stable(b_out));
  // R4
  ba_desel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ba_sel_n |=> $stable(a_out));
  // R5
  ab_drive_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (b_drv == $past(!ab_sel_n && !ab_drv_n)));
  // R6
  ba_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!ba_sel_n && !ba_cap_n) |=> (a_out == $past(b_in)));
  // R6
  ba_drive_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (a_drv == $past(!ba_sel_n && !ba_drv_n)));
  // R8
  no_drive_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (ab_sel_n || ab_drv_n) |=> !b_drv);
endmodule

bind bus_xcvr_latched bus_xcvr_latched_chk #(.W(W)) chk_i (.*);

// File: tb/bus_xcvr_latched_tb_top.sv
`timescale 1ns/1ps
module bus_xcvr_latched_tb_top;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_sel_n = 1, ab_cap_n = 1, ab_drv_n = 1;
  logic ba_sel_n = 1, ba_cap_n = 1, ba_drv_n = 1;
  logic [W-1:0] a_out, b_out;
  logic a_drv, b_drv;

  int checks = 0, errors = 0;
  logic [W-1:0] e_ab = '0, e_ba = '0;
  logic e_bdrv = 0, e_adrv = 0;

  always #2 clk = ~clk;

  bus_xcvr_latched #(.W(W)) dut_i (.*);

  // reference model, updated on the same edge the design samples
  always @(posedge clk) begin
    if (rst) begin
      e_ab <= '0; e_ba <= '0; e_bdrv <= 0; e_adrv <= 0;
    end else begin
      if (!ab_sel_n && !ab_cap_n) e_ab <= a_in;
      if (!ba_sel_n && !ba_cap_n) e_ba <= b_in;
      e_bdrv <= !ab_sel_n && !ab_drv_n;
      e_adrv <= !ba_sel_n && !ba_drv_n;
    end
  end

  function automatic logic drv_exp(input logic sel_n, input logic drv_n);
    return !sel_n && !drv_n;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // apply inputs after negedge, let one posedge pass, compare at next negedge
  task automatic step(input string req);
    @(posedge clk);
    @(negedge clk);
    chk({req, " b_out"}, b_out, e_ab);
    chk({req, " a_out"}, a_out, e_ba);
    chk({req, " b_drv"}, {7'd0, b_drv}, {7'd0, e_bdrv});
    chk({req, " a_drv"}, {7'd0, a_drv}, {7'd0, e_adrv});
  endtask

  task automatic set_ab(input logic s, input logic c, input logic d);
    ab_sel_n = s; ab_cap_n = c; ab_drv_n = d;
  endtask
  task automatic set_ba(input logic s, input logic c, input logic d);
    ba_sel_n = s; ba_cap_n = c; ba_drv_n = d;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    @(negedge clk);
    a_in = 8'hA5; b_in = 8'h5A;
    set_ab(0, 0, 0); set_ba(0, 0, 0);
    step("R1 reset");
    chk("R1 b_out zero", b_out, 8'h00);
    chk("R1 a_drv zero", {7'd0, a_drv}, 8'h00);
    rst = 0;
    set_ab(1, 1, 1); set_ba(1, 1, 1);
    step("R1 idle");

    // R2 transparent follow, then R3 hold on rising capture
    a_in = 8'h3C; set_ab(0, 0, 1);
    step("R2 follow");
    chk("R2 b_out load", b_out, 8'h3C);
    a_in = 8'hC3; step("R2 follow2");
    chk("R2 b_out follow", b_out, 8'hC3);
    ab_cap_n = 1; a_in = 8'h11; step("R3 hold");
    chk("R3 b_out held", b_out, 8'hC3);
    a_in = 8'h22; step("R3 hold2");
    chk("R3 b_out still", b_out, 8'hC3);

    // R4 deselected with capture low keeps the word
    set_ab(1, 0, 0); a_in = 8'h99; step("R4 desel");
    chk("R4 b_out kept", b_out, 8'hC3);
    chk("R5 b_drv off when deselected", {7'd0, b_drv}, 8'h00);

    // R5 drive on, same-edge load and drive
    set_ab(0, 0, 0); a_in = 8'h77; step("R5 load+drive");
    chk("R5 b_drv on", {7'd0, b_drv}, 8'h01);
    chk("R5 b_out new word with drive", b_out, 8'h77);

    // R6 B-to-A path, R7 independence: both transparent together
    set_ba(0, 0, 0); a_in = 8'h0F; b_in = 8'hF0; step("R7 both");
    chk("R7 b_out own", b_out, 8'h0F);
    chk("R6 a_out own", a_out, 8'hF0);
    set_ab(1, 1, 1); a_in = 8'hEE; b_in = 8'h44; step("R7 ab off");
    chk("R7 a_out unaffected", a_out, 8'h44);
    chk("R7 b_out held", b_out, 8'h0F);
    ba_cap_n = 1; b_in = 8'h55; step("R6 hold");
    chk("R6 a_out held", a_out, 8'h44);
    ba_sel_n = 1; ba_cap_n = 0; b_in = 8'h66; step("R4 ba desel");
    chk("R4 a_out kept", a_out, 8'h44);

    // random phase with external drivers that respect the model
    for (int i = 0; i < 3000; i++) begin
      logic ext_a, ext_b;
      set_ab($urandom_range(0, 3) == 0, $urandom_range(0, 1), $urandom_range(0, 1));
      set_ba($urandom_range(0, 3) == 0, $urandom_range(0, 1), $urandom_range(0, 1));
      ext_a = !drv_exp(ba_sel_n, ba_drv_n) && $urandom_range(0, 1);
      ext_b = !drv_exp(ab_sel_n, ab_drv_n) && $urandom_range(0, 1);
      if (ext_a) a_in = W'($urandom);
      if (ext_b) b_in = W'($urandom);
      step("R7 random");
      checks++;
      if ((ext_a && a_drv) || (ext_b && b_drv)) begin
        errors++;
        $display("FAIL R8 contention actual=%b%b expected=00", ext_a && a_drv, ext_b && b_drv);
      end
    end

    // reset mid-run clears everything again
    rst = 1; step("R1 rerun");
    chk("R1 a_out cleared", a_out, 8'h00);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule